// File: doc/BRIEF.md
# Edge-Selectable Interrupt Request Multiplexer

This block turns activity on six external interrupt pins and several internal peripheral pulses into eight latched interrupt request flags. Each pin is synchronized to the system clock. It then fires on a single edge, either rising or falling as a per-channel polarity bit selects, or on both edges when that channel's both-edge bit is set. The both-edge bit overrides the polarity bit.

Slots 0 to 3 belong to pins 0 to 3. Slots 4 and 5 are shared: each one takes either a serial I/O request pulse or the event from pin 4 or pin 5. Slots 6 and 7 are also shared: each one takes either a timer request pulse or a UART bus-collision pulse. Route bits choose the source of every shared slot.

Software reaches the block through a byte-wide register port. Each flag stays set until software writes 0 to its bit. This lets software discard a spurious request after it changes a route bit, before it enables that interrupt.

Top module: `irq_edge_mux`

## Requirements
- R1: After reset the flags are 0, and all four registers read 0x00. The registers are: edge/route register at address 0, peripheral route register at address 1, polarity register at address 2, flag register at address 3.
- R2: When a channel's both-edge bit (address 0, bit n) is 0 and its polarity bit (address 2, bit n) is 0, a falling edge on the pin sets its flag. A rising edge does not.
- R3: When the both-edge bit is 0 and the polarity bit is 1, only a rising edge sets the flag.
- R4: When the both-edge bit is 1, either edge sets the flag, whatever the polarity bit holds.
- R5: The flag sets at the third rising clock edge after the pin changes, and not at the second.
- R6: A set flag stays set. Writing 0 to its bit at address 3 clears it, and writing 1 leaves it unchanged. Reading address 3 returns the flag vector.
- R7: If a slot's source fires in the same cycle as a write that clears its bit, the flag ends up set.
- R8: Address 0 bit 6 routes serial request 0 (value 0) or pin 4 (value 1) into slot 4. Bit 7 does the same for serial request 1 or pin 5 into slot 5. The unselected source never sets the flag.
- R9: Address 1 bit 6 routes timer request 0 (value 0) or bus-collision request 0 (value 1) into slot 6. Bit 7 does the same for timer request 1 or bus-collision request 1 into slot 7. The unselected source never sets the flag.
- R10: Address 1 bits 5:0 and address 2 bits 7:6 ignore writes and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 6 | External interrupt pins, asynchronous |
| sio_req | input | 2 | Serial I/O request pulses for slots 4 and 5 |
| tmr_req | input | 2 | Timer request pulses for slots 6 and 7 |
| bcol_req | input | 2 | UART bus-collision pulses for slots 6 and 7 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq_flag | output | 8 | Latched request flags, one per slot |

## Verification
Every internal fault ends up in a flag bit or in a register read. A wrong synchronizer depth or a wrong edge-register reset shifts the cycle in which a flag sets, or sets a flag with no edge. The bench therefore checks the flag at both the second and the third clock after a pin change. A route bit that steers the wrong way lets a pulse from the unselected source set the flag on the very next edge. A fault in the clear path shows up at the next flag read, as a flag that survives a clear or is lost to one.

// File: rtl/irq_edge_mux_pkg.sv
package irq_edge_mux_pkg;

  typedef enum logic [1:0] {
    ADDR_EDGE  = 2'd0,
    ADDR_ROUTE = 2'd1,
    ADDR_POL   = 2'd2,
    ADDR_FLAG  = 2'd3
  } reg_addr_e;

  // Qualifying-edge test for one synchronized channel.
  function automatic logic edge_hit(input logic both, input logic rise_sel,
                                    input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (both) return rise | fall;
    return rise_sel ? rise : fall;
  endfunction

  // Two-way source steering for a shared slot.
  function automatic logic pick(input logic sel, input logic src0, input logic src1);
    return sel ? src1 : src0;
  endfunction

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge
  import irq_edge_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic both,
  input  logic rise_sel,
  output logic evt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign evt = edge_hit(both, rise_sel, sync_q[SYNC_STAGES-1], prev_q);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_edge_mux_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int NUM_ROUTE = 2,
  localparam int DATA_W = NUM_PINS + NUM_ROUTE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    flags,
  output logic [DATA_W-1:0]    rdata,
  output logic [NUM_PINS-1:0]  edge_both,
  output logic [NUM_PINS-1:0]  rise_sel,
  output logic [NUM_ROUTE-1:0] pin_route,
  output logic [NUM_ROUTE-1:0] slot_route,
  output logic [DATA_W-1:0]    flag_clr
);
  logic [DATA_W-1:0]    edge_q;
  logic [NUM_PINS-1:0]  rise_q;
  logic [NUM_ROUTE-1:0] route_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q  <= '0;
      rise_q  <= '0;
      route_q <= '0;
    end else if (we) begin
      case (addr)
        ADDR_EDGE:  edge_q  <= wdata;
        ADDR_ROUTE: route_q <= wdata[DATA_W-1 -: NUM_ROUTE];
        ADDR_POL:   rise_q  <= wdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  assign edge_both  = edge_q[NUM_PINS-1:0];
  assign pin_route  = edge_q[DATA_W-1 -: NUM_ROUTE];
  assign rise_sel   = rise_q;
  assign slot_route = route_q;
  assign flag_clr   = (we && addr == ADDR_FLAG) ? ~wdata : '0;

  always_comb begin
    case (addr)
      ADDR_EDGE:  rdata = edge_q;
      ADDR_ROUTE: rdata = {route_q, {NUM_PINS{1'b0}}};
      ADDR_POL:   rdata = {{NUM_ROUTE{1'b0}}, rise_q};
      default:    rdata = flags;
    endcase
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] set_evt,
  input  logic [NUM_SLOTS-1:0] clr,
  output logic [NUM_SLOTS-1:0] flag
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag[s] <= 1'b0;
      else if (set_evt[s]) flag[s] <= 1'b1;
      else if (clr[s])     flag[s] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_edge_mux.sv
module irq_edge_mux
  import irq_edge_mux_pkg::*;
#(
  parameter int NUM_PINS    = 6,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_SHARED = 2,
  localparam int NUM_DED    = NUM_PINS - NUM_SHARED,
  localparam int NUM_PERI   = 2,
  localparam int NUM_SLOTS  = NUM_PINS + NUM_PERI,
  localparam int DATA_W     = NUM_SLOTS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   ext_pin,
  input  logic [NUM_SHARED-1:0] sio_req,
  input  logic [NUM_PERI-1:0]   tmr_req,
  input  logic [NUM_PERI-1:0]   bcol_req,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic [NUM_SLOTS-1:0]  irq_flag
);
  // Named internal events, observed by the bound checker.
  logic [NUM_PINS-1:0]   ext_evt;
  logic [NUM_SLOTS-1:0]  slot_evt;
  logic [NUM_SLOTS-1:0]  flag_clr;
  logic [NUM_PINS-1:0]   edge_both;
  logic [NUM_PINS-1:0]   rise_sel;
  logic [NUM_SHARED-1:0] pin_route;
  logic [NUM_PERI-1:0]   slot_route;

  irq_cfg_regs #(.NUM_PINS(NUM_PINS), .NUM_ROUTE(NUM_SHARED)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .flags      (irq_flag),
    .rdata      (reg_rdata),
    .edge_both  (edge_both),
    .rise_sel   (rise_sel),
    .pin_route  (pin_route),
    .slot_route (slot_route),
    .flag_clr   (flag_clr)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (ext_pin[i]),
      .both     (edge_both[i]),
      .rise_sel (rise_sel[i]),
      .evt      (ext_evt[i])
    );
    if (i < NUM_DED) begin : g_ded
      assign slot_evt[i] = ext_evt[i];
    end else begin : g_shr
      assign slot_evt[i] = pick(pin_route[i-NUM_DED], sio_req[i-NUM_DED], ext_evt[i]);
    end
  end

  for (genvar j = 0; j < NUM_PERI; j++) begin : g_peri
    assign slot_evt[NUM_PINS+j] = pick(slot_route[j], tmr_req[j], bcol_req[j]);
  end

  irq_flag_bank #(.NUM_SLOTS(NUM_SLOTS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (slot_evt),
    .clr     (flag_clr),
    .flag    (irq_flag)
  );
endmodule

// File: rtl/irq_edge_mux_chk.sv
module irq_edge_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] slot_evt,
  input logic [7:0] flag_clr,
  input logic [7:0] irq_flag,
  input logic [1:0] shr_evt,
  input logic [1:0] pin_route,
  input logic [1:0] slot_route,
  input logic [1:0] sio_req,
  input logic [1:0] tmr_req,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_rdata
);
  // R7: a slot event always leaves its flag set, even against a clear.
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_evt != 8'h00) |=> ((irq_flag & $past(slot_evt)) == $past(slot_evt)));

  // R6: a clear strobe with no event empties the flag.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != 8'h00) |=> ((irq_flag & $past(flag_clr & ~slot_evt)) == 8'h00));

  // R6: a flag rises only where an event was seen.
  p_new_flag_needs_evt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag != 8'hFF) |=> (((irq_flag & ~$past(irq_flag)) & ~$past(slot_evt)) == 8'h00));

  // R6: a flag with no clear stays set.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag != 8'h00) |=> ((irq_flag & $past(irq_flag & ~flag_clr)) == $past(irq_flag & ~flag_clr)));

  for (genvar k = 0; k < 2; k++) begin : g_shared
    // R8: unselected source cannot create a slot event.
    p_pin_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_route[k] && !shr_evt[k]) |-> !slot_evt[4+k]);
    p_sio_side_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_route[k] && !sio_req[k]) |-> !slot_evt[4+k]);
    // R9: timer side selected and idle means no event.
    p_tmr_side_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!slot_route[k] && !tmr_req[k]) |-> !slot_evt[6+k]);
  end

  // R10: unimplemented bits read zero.
  p_route_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd1) |-> (reg_rdata[5:0] == 6'd0));
  p_pol_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd2) |-> (reg_rdata[7:6] == 2'd0));
endmodule

bind irq_edge_mux irq_edge_mux_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_evt   (slot_evt),
  .flag_clr   (flag_clr),
  .irq_flag   (irq_flag),
  .shr_evt    (ext_evt[5:4]),
  .pin_route  (pin_route),
  .slot_route (slot_route),
  .sio_req    (sio_req),
  .tmr_req    (tmr_req),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata)
);

// File: tb/irq_edge_mux_tb.sv
module irq_edge_mux_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] ext_pin = '0;
  logic [1:0] sio_req = '0;
  logic [1:0] tmr_req = '0;
  logic [1:0] bcol_req = '0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [7:0] irq_flag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  irq_edge_mux u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .sio_req(sio_req),
    .tmr_req(tmr_req), .bcol_req(bcol_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_flag(irq_flag)
  );

  // Vector: {edge reg, polarity reg, pin, level before, level after, flag expected}
  localparam int NV = 10;
  localparam logic [19:0] VECS [NV] = '{
    {8'hC0, 6'h00, 3'd0, 1'b1, 1'b0, 1'b1},  // R2 falling sets
    {8'hC0, 6'h00, 3'd0, 1'b0, 1'b1, 1'b0},  // R2 rising ignored
    {8'hC0, 6'h02, 3'd1, 1'b0, 1'b1, 1'b1},  // R3 rising sets
    {8'hC0, 6'h02, 3'd1, 1'b1, 1'b0, 1'b0},  // R3 falling ignored
    {8'hC4, 6'h00, 3'd2, 1'b0, 1'b1, 1'b1},  // R4 both, rising
    {8'hC4, 6'h00, 3'd2, 1'b1, 1'b0, 1'b1},  // R4 both, falling
    {8'hC8, 6'h08, 3'd3, 1'b1, 1'b0, 1'b1},  // R4 both overrides polarity
    {8'hC0, 6'h10, 3'd4, 1'b0, 1'b1, 1'b1},  // R8 pin 4 routed
    {8'h40, 6'h00, 3'd5, 1'b1, 1'b0, 1'b0},  // R8 pin 5 not routed
    {8'hE0, 6'h20, 3'd5, 1'b1, 1'b0, 1'b1}   // R8 pin 5 routed, both edges
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);

    // R1 reset state
    check("R1 flags", irq_flag, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], rv);
      check("R1 register", rv, 8'h00);
    end

    // Table walk: edge modes, latency and pin routing
    for (int v = 0; v < NV; v++) begin
      logic [7:0] e;
      logic [5:0] p;
      logic [2:0] pin;
      logic l0, l1, ex;
      {e, p, pin, l0, l1, ex} = VECS[v];
      wr(2'd0, e);
      wr(2'd2, {2'b00, p});
      ext_pin[pin] = l0;
      wait_n(4);
      wr(2'd3, 8'h00);
      ext_pin[pin] = l1;
      wait_n(2);
      check("R5 not yet at second edge", irq_flag, 8'h00);
      wait_n(1);
      check("R2/R3/R4/R8 table vector", irq_flag, ex ? (8'h01 << pin) : 8'h00);
      ext_pin[pin] = 1'b0;
      wait_n(4);
      wr(2'd3, 8'h00);
    end

    // R8: serial sources while route bits are 0
    wr(2'd0, 8'h00);
    ext_pin[4] = 1'b1; wait_n(4); ext_pin[4] = 1'b0; wait_n(4);
    check("R8 pin 4 ignored when serial selected", irq_flag, 8'h00);
    sio_req[0] = 1'b1; wait_n(1); sio_req[0] = 1'b0;
    check("R8 serial 0 into slot 4", irq_flag, 8'h10);
    sio_req[1] = 1'b1; wait_n(1); sio_req[1] = 1'b0;
    check("R8 serial 1 into slot 5", irq_flag, 8'h30);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'hC0);
    sio_req = 2'b11; wait_n(1); sio_req = 2'b00;
    check("R8 serial ignored when pins selected", irq_flag, 8'h00);

    // R9 and R6: timer path, sticky flag, clear semantics
    tmr_req[0] = 1'b1; wait_n(1); tmr_req[0] = 1'b0;
    check("R9 timer 0 into slot 6", irq_flag, 8'h40);
    bcol_req = 2'b11; wait_n(1); bcol_req = 2'b00;
    check("R9 collision ignored when timer selected", irq_flag, 8'h40);
    wr(2'd3, 8'hFF);
    wait_n(5);
    check("R6 write of ones keeps flag", irq_flag, 8'h40);
    rd(2'd3, rv);
    check("R6 flag register read", rv, 8'h40);
    wr(2'd3, 8'hBF);
    check("R6 zero bit clears", irq_flag, 8'h00);
    wr(2'd1, 8'hC0);
    tmr_req = 2'b11; wait_n(1); tmr_req = 2'b00;
    check("R9 timer ignored when collision selected", irq_flag, 8'h00);
    bcol_req[1] = 1'b1; wait_n(1); bcol_req[1] = 1'b0;
    check("R9 collision 1 into slot 7", irq_flag, 8'h80);

    // R7: event and clear in the same cycle
    wr(2'd1, 8'h00);
    reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00; tmr_req[0] = 1'b1;
    wait_n(1);
    reg_we = 1'b0; tmr_req[0] = 1'b0;
    check("R7 set wins over clear", irq_flag, 8'h40);
    wr(2'd3, 8'h00);

    // R10: unimplemented bits
    wr(2'd1, 8'hFF);
    rd(2'd1, rv);
    check("R10 route register low bits", rv, 8'hC0);
    wr(2'd2, 8'hFF);
    rd(2'd2, rv);
    check("R10 polarity register high bits", rv, 8'h3F);
    wr(2'd0, 8'hA5);
    rd(2'd0, rv);
    check("R10 edge register full width", rv, 8'hA5);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule